// File: doc/BRIEF.md
# Register Rename and Value Table

This block is the single table behind register renaming in an out-of-order core. It has one entry per architectural register. Each entry keeps three things: a ready flag, the tag of the reorder-buffer slot that will produce the register, and the committed value. The flag alone tells a consumer which of the other two fields to take.

At dispatch the table answers two source lookups in parallel, combinationally, in the same cycle. A source whose register is ready returns its value. A source whose register is pending returns the producer tag. On the clock edge that ends the dispatch cycle, the destination register is marked pending on the tag of the new reorder-buffer tail.

At retirement the result is written into the destination register. The flag is raised again only when the register still names the retiring tag, so a younger producer keeps its claim.

Both streams are plain valid-qualified transfers with no ready return. The table can take a dispatch and a retire in every cycle, so it never applies back-pressure. Stalling on a full reorder buffer belongs to the sender, which simply holds its valid low.

Top module: `rename_value_table`

## Requirements
- R1: After reset every register reads as ready with value zero.
- R2: A source lookup of a ready register returns rdy=1, data equal to the committed value, and tag=0, in the same cycle the source index is presented.
- R3: A source lookup of a pending register returns rdy=0, tag equal to the producer tag, and data=0.
- R4: The two source lookups are independent. Each returns its own register's state in the same cycle, including when both name the same register.
- R5: A dispatch (disp_valid=1) makes disp_dst read as pending with tag disp_tag from the cycle after the dispatch onward.
- R6: Lookups return the state from before the edge. An instruction whose source equals its own destination sees the older state, not its own new tag.
- R7: A retire (ret_valid=1) whose ret_tag equals the tag held by ret_dst writes ret_value and makes the register ready from the next cycle.
- R8: A retire whose ret_tag differs from the tag held by a pending ret_dst leaves that register pending with its held tag unchanged.
- R9: When a dispatch and a retire name the same register in the same cycle, the register ends pending with the new dispatch tag.
- R10: A dispatch and a retire to different registers in the same cycle both take effect. Registers named by neither keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_src_a | input | IDX_W | First source register index |
| disp_src_b | input | IDX_W | Second source register index |
| disp_dst | input | IDX_W | Destination register being renamed |
| disp_tag | input | TAG_W | Reorder-buffer tail tag of the dispatching instruction |
| src_a_rdy | output | 1 | First source is ready |
| src_a_data | output | DATA_W | First source value (0 when pending) |
| src_a_tag | output | TAG_W | First source producer tag (0 when ready) |
| src_b_rdy | output | 1 | Second source is ready |
| src_b_data | output | DATA_W | Second source value (0 when pending) |
| src_b_tag | output | TAG_W | Second source producer tag (0 when ready) |
| ret_valid | input | 1 | A retire is presented this cycle |
| ret_dst | input | IDX_W | Destination register of the retiring entry |
| ret_tag | input | TAG_W | Tag of the retiring entry |
| ret_value | input | DATA_W | Result value being retired |

## Verification
Lookup results are due in the same cycle as the source indices, with zero register delay. Dispatch and retire effects are due exactly one edge later. The bench drives inputs on the falling edge and compares the lookup outputs 1 ns later, against a behavioural model holding the state from before the coming edge. It then advances the model on the rising edge, so an update is first observed by the lookups of the following cycle. Directed cycles cover reset, own-destination sources, stale and matching retires, and same-register collisions. A seeded random phase then compares every cycle.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
  typedef enum logic [1:0] {
    SLOT_HOLD   = 2'd0,
    SLOT_RENAME = 2'd1,
    SLOT_COMMIT = 2'd2,
    SLOT_WRITE  = 2'd3
  } slot_op_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/rvt_slot.sv
module rvt_slot
  import rvt_pkg::*;
#(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLOT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [IDX_W-1:0]  disp_dst,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_dst,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_value,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT_ID);

  logic              vld_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              hit_disp;
  logic              hit_ret;
  slot_op_e          op;

  assign hit_disp = disp_valid && (disp_dst == MY_IDX);
  assign hit_ret  = ret_valid && (ret_dst == MY_IDX);

  // Rename takes priority over any retire landing on the same slot.
  always_comb begin
    if (hit_disp)                op = SLOT_RENAME;
    else if (!hit_ret)           op = SLOT_HOLD;
    else if (ret_tag == tag_q)   op = SLOT_COMMIT;
    else                         op = SLOT_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b1;
      tag_q <= '0;
      val_q <= '0;
    end else begin
      case (op)
        SLOT_RENAME: begin
          vld_q <= 1'b0;
          tag_q <= disp_tag;
          if (hit_ret) val_q <= ret_value;
        end
        SLOT_COMMIT: begin
          vld_q <= 1'b1;
          val_q <= ret_value;
        end
        SLOT_WRITE: val_q <= ret_value;
        default: ;
      endcase
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
  assign val_o = val_q;

  // R5 and R9: a rename leaves the slot pending on the new tag, whatever retires.
  a_r5_rename_pending: assert property (@(posedge clk) disable iff (!rst_n)
    hit_disp |=> (!vld_q && tag_q == $past(disp_tag)));

  // R7: a retire carrying the held tag commits the value.
  a_r7_commit_match: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ret && !hit_disp && ret_tag == tag_q) |=> (vld_q && val_q == $past(ret_value)));

  // R8: a stale retire keeps a younger producer's claim.
  a_r8_stale_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ret && !hit_disp && ret_tag != tag_q && !vld_q) |=> (!vld_q && $stable(tag_q)));

  // R10: an untouched slot keeps all of its state.
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ret && !hit_disp) |=> ($stable(vld_q) && $stable(tag_q) && $stable(val_q)));
endmodule

// File: rtl/rvt_read_port.sv
module rvt_read_port #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned DATA_W   = 16
) (
  input  logic [IDX_W-1:0]                 sel,
  input  logic [NUM_REGS-1:0]              vld_vec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_vec,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_vec,
  output logic                             rdy,
  output logic [DATA_W-1:0]                data,
  output logic [TAG_W-1:0]                 tag
);
  logic              sel_vld;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_vld = 1'b0;
    sel_tag = '0;
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel == IDX_W'(i)) begin
        sel_vld = vld_vec[i];
        sel_tag = tag_vec[i];
        sel_val = val_vec[i];
      end
    end
  end

  // The ready flag chooses which field is live; the other reads as zero.
  assign rdy  = sel_vld;
  assign data = sel_vld ? sel_val : '0;
  assign tag  = sel_vld ? '0 : sel_tag;

  // R2 and R3: exactly one of the two fields can be live.
  always_comb begin
    a_r3_exclusive_fields: assert (!(rdy && tag != '0) && !(!rdy && data != '0));
  end
endmodule

// File: rtl/rename_value_table.sv
module rename_value_table
  import rvt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [IDX_W-1:0]  disp_src_a,
  input  logic [IDX_W-1:0]  disp_src_b,
  input  logic [IDX_W-1:0]  disp_dst,
  input  logic [TAG_W-1:0]  disp_tag,
  output logic              src_a_rdy,
  output logic [DATA_W-1:0] src_a_data,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_b_rdy,
  output logic [DATA_W-1:0] src_b_data,
  output logic [TAG_W-1:0]  src_b_tag,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_dst,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_value
);
  logic [NUM_REGS-1:0]             vld_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_vec;

  logic [NUM_SRC-1:0][IDX_W-1:0]   src_sel;
  logic [NUM_SRC-1:0]              src_rdy;
  logic [NUM_SRC-1:0][DATA_W-1:0]  src_data;
  logic [NUM_SRC-1:0][TAG_W-1:0]   src_tag;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    rvt_slot #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .SLOT_ID(g)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_tag(disp_tag),
      .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_tag(ret_tag),
      .ret_value(ret_value),
      .vld_o(vld_vec[g]), .tag_o(tag_vec[g]), .val_o(val_vec[g])
    );
  end

  assign src_sel[0] = disp_src_a;
  assign src_sel[1] = disp_src_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_port
    rvt_read_port #(
      .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_port (
      .sel(src_sel[s]), .vld_vec(vld_vec), .tag_vec(tag_vec), .val_vec(val_vec),
      .rdy(src_rdy[s]), .data(src_data[s]), .tag(src_tag[s])
    );
  end

  assign src_a_rdy  = src_rdy[0];
  assign src_a_data = src_data[0];
  assign src_a_tag  = src_tag[0];
  assign src_b_rdy  = src_rdy[1];
  assign src_b_data = src_data[1];
  assign src_b_tag  = src_tag[1];

  // R4: two lookups of one register agree.
  a_r4_same_reg_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_src_a == disp_src_b) |-> (src_a_rdy == src_b_rdy && src_a_tag == src_b_tag
                                    && src_a_data == src_b_data));
endmodule

// File: tb/rename_value_table_test.sv
`timescale 1ns/1ps
module rename_value_table_test;
  localparam int NR = 8, TW = 4, DW = 16, IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, ret_valid = 1'b0;
  logic [IW-1:0] disp_src_a = '0, disp_src_b = '0, disp_dst = '0, ret_dst = '0;
  logic [TW-1:0] disp_tag = '0, ret_tag = '0;
  logic [DW-1:0] ret_value = '0;
  logic src_a_rdy, src_b_rdy;
  logic [DW-1:0] src_a_data, src_b_data;
  logic [TW-1:0] src_a_tag, src_b_tag;

  int checks = 0, failures = 0;
  bit done = 0;

  logic          m_vld [NR];
  logic [TW-1:0] m_tag [NR];
  logic [DW-1:0] m_val [NR];

  always #2.5 clk = ~clk;

  rename_value_table #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
    .disp_dst(disp_dst), .disp_tag(disp_tag),
    .src_a_rdy(src_a_rdy), .src_a_data(src_a_data), .src_a_tag(src_a_tag),
    .src_b_rdy(src_b_rdy), .src_b_data(src_b_data), .src_b_tag(src_b_tag),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_tag(ret_tag), .ret_value(ret_value)
  );

  task automatic check_src(input string lbl, input logic rdy, input logic [DW-1:0] d,
                           input logic [TW-1:0] t, input int r);
    logic [DW-1:0] ed;
    logic [TW-1:0] et;
    ed = m_vld[r] ? m_val[r] : '0;
    et = m_vld[r] ? '0 : m_tag[r];
    checks++;
    if (rdy !== m_vld[r] || d !== ed || t !== et) begin
      failures++;
      $display("FAIL %s (%s) reg %0d: got rdy=%0b data=%h tag=%h, expected rdy=%0b data=%h tag=%h",
               lbl, m_vld[r] ? "R2" : "R3", r, rdy, d, t, m_vld[r], ed, et);
    end
  endtask

  // One cycle: inputs set after the falling edge, lookups compared 1 ns later,
  // model advanced on the rising edge (retire first, rename overrides: R9).
  task automatic cycle(input string lbl, input bit dv, input int sa, input int sb,
                       input int dd, input int dt, input bit rv, input int rd,
                       input int rt, input int rval);
    disp_valid = dv; disp_src_a = IW'(sa); disp_src_b = IW'(sb);
    disp_dst = IW'(dd); disp_tag = TW'(dt);
    ret_valid = rv; ret_dst = IW'(rd); ret_tag = TW'(rt); ret_value = DW'(rval);
    #1;
    check_src({lbl, " srcA"}, src_a_rdy, src_a_data, src_a_tag, sa);
    check_src({lbl, " srcB"}, src_b_rdy, src_b_data, src_b_tag, sb);
    @(posedge clk);
    if (rv) begin
      m_val[rd] = DW'(rval);
      if (m_tag[rd] == TW'(rt)) m_vld[rd] = 1'b1;
    end
    if (dv) begin
      m_vld[dd] = 1'b0;
      m_tag[dd] = TW'(dt);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_vld[i] = 1; m_tag[i] = '0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all registers ready and zero after reset
    for (int i = 0; i < NR; i += 2) cycle("R1 reset", 0, i, i + 1, 0, 0, 0, 0, 0, 0);
    // R5 and R6: rename r3 while reading r3 as its own source
    cycle("R6 own dest", 1, 3, 3, 3, 5, 0, 0, 0, 0);
    cycle("R5 pending", 0, 3, 2, 0, 0, 0, 0, 0, 0);
    // R7: matching retire commits
    cycle("R7 commit", 0, 1, 1, 0, 0, 1, 3, 5, 16'h1234);
    cycle("R7 after", 0, 3, 3, 0, 0, 0, 0, 0, 0);
    // R8: two renames of r4, then an old retire must not clear pending
    cycle("R8 setup1", 1, 0, 0, 4, 6, 0, 0, 0, 0);
    cycle("R8 setup2", 1, 4, 0, 4, 7, 0, 0, 0, 0);
    cycle("R8 stale", 0, 4, 4, 0, 0, 1, 4, 6, 16'hAAAA);
    cycle("R8 after", 0, 4, 4, 0, 0, 1, 4, 7, 16'hBBBB);
    cycle("R7 younger", 0, 4, 3, 0, 0, 0, 0, 0, 0);
    // R9: rename and matching retire of r5 in the same cycle
    cycle("R9 setup", 1, 5, 0, 5, 8, 0, 0, 0, 0);
    cycle("R9 collide", 1, 5, 6, 5, 9, 1, 5, 8, 16'hCCCC);
    cycle("R9 after", 0, 5, 5, 0, 0, 0, 0, 0, 0);
    // R10: rename r6 while r5 retires; R4: different sources in one cycle
    cycle("R10 split", 1, 5, 6, 6, 10, 1, 5, 9, 16'h0F0F);
    cycle("R10 after", 0, 5, 6, 0, 0, 0, 0, 0, 0);
    cycle("R4 pair", 0, 6, 7, 0, 0, 0, 0, 0, 0);
    // Random phase: R2 R3 R4 R10 compared every cycle
    for (int n = 0; n < 400; n++) begin
      int rd, rt;
      rd = $urandom_range(NR - 1);
      rt = ($urandom_range(3) != 0) ? int'(m_tag[rd]) : $urandom_range(15);
      cycle("rand", 1'($urandom_range(1)), $urandom_range(NR - 1), $urandom_range(NR - 1),
            $urandom_range(NR - 1), $urandom_range(15), 1'($urandom_range(1)), rd, rt,
            $urandom_range(65535));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule